// File: doc/BRIEF.md
# Offset and Gain Calibration Engine

This block sits behind a converter's modulator and digital filter. It turns each raw signed result into a corrected result. First it subtracts a stored offset coefficient from the raw value. It then multiplies the difference by a stored unsigned full-scale coefficient, clamps the product to the representable code range, and places the result in an output data register with a one-cycle valid pulse.

The same block also learns its two coefficients. Control logic writes a calibration code into the mode register. There are two zero-scale captures and two full-scale captures, and each kind can take its input from an internal or a system source. A `src_system` output tells the analog side which source to connect. A zero-scale capture stores the next raw sample as the offset. A full-scale capture divides positive full scale by the next offset-corrected sample, using a serial divider, and stores the quotient as the gain. When either capture finishes, the mode register falls back to idle and a done flag rises.

Top module: `cal_engine`

## Requirements
- R1: After reset the offset is 0, the gain is unity (2^(COEF_W-1), 0x800000 by default), the mode register reads 000, and `cal_done`, `dout_valid` and `src_system` are 0.
- R2: In idle mode, a raw sample with `raw_valid` yields `dout_valid` high for exactly one cycle, on the following clock edge. On that edge `dout` = floor((raw - offset) * gain / 2^(COEF_W-1)).
- R3: The corrected result saturates: values above 2^(DATA_W-1)-1 give that maximum code, and values below -2^(DATA_W-1) give the minimum code.
- R4: Mode codes are 000 idle, 100 internal zero-scale, 101 internal full-scale, 110 system zero-scale and 111 system full-scale. A write is accepted only while the mode is idle. Codes 001 to 011 store as idle. A write made while a capture is pending is ignored.
- R5: In a zero-scale mode, the next raw sample becomes the offset and is not output. On the same edge the mode returns to idle and `cal_done` rises.
- R6: In a full-scale mode, the next raw sample gives d = raw - offset. The gain becomes floor((2^(DATA_W-1)-1) * 2^(COEF_W-1) / d), clamped to all ones. If d <= 0, the gain becomes all ones at once. Samples that arrive while the division runs are neither output nor captured.
- R7: `src_system` is 1 exactly while the mode is 110 or 111.
- R8: `cal_done` stays high until a mode write is accepted, and it is 0 after that write's edge.
- R9: When a mode write and a raw sample arrive in the same cycle while idle, the sample is converted with the current coefficients. The calibration then takes a later sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode code to write |
| raw_valid | input | 1 | Raw sample strobe |
| raw_data | input | DATA_W | Raw signed sample |
| mode_q | output | 3 | Current mode register |
| src_system | output | 1 | Selects the system input source during capture |
| cal_done | output | 1 | Calibration completed flag |
| dout_valid | output | 1 | One-cycle pulse for a new corrected result |
| dout | output | DATA_W | Corrected, saturated result register |
| offset_q | output | DATA_W | Offset coefficient |
| gain_q | output | COEF_W | Full-scale coefficient |

## Verification
A mode write and a sample strobe can land on the same clock edge. The block must decide whether that sample is a normal conversion or the calibration input. The bench raises both strobes together while the engine is idle. It then expects a corrected output computed with the old coefficients, a mode register holding the new code, and an offset that stays the same until a later sample arrives. A second collision is also provoked: a mode write that comes while a capture is pending must leave the mode register unchanged.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE     = 3'b000,
    MODE_INT_ZERO = 3'b100,
    MODE_INT_FULL = 3'b101,
    MODE_SYS_ZERO = 3'b110,
    MODE_SYS_FULL = 3'b111
  } cal_mode_e;

  // Codes without bit 2 set carry no calibration request.
  function automatic cal_mode_e norm_mode(input logic [2:0] code);
    return code[2] ? cal_mode_e'(code) : MODE_IDLE;
  endfunction

  function automatic logic is_zero_cap(input cal_mode_e m);
    return (m == MODE_INT_ZERO) || (m == MODE_SYS_ZERO);
  endfunction

  function automatic logic is_full_cap(input cal_mode_e m);
    return (m == MODE_INT_FULL) || (m == MODE_SYS_FULL);
  endfunction

  function automatic logic is_system(input cal_mode_e m);
    return (m == MODE_SYS_ZERO) || (m == MODE_SYS_FULL);
  endfunction

endpackage

// File: rtl/cal_divider.sv
`timescale 1ns/1ps
// Restoring divider: one quotient bit per cycle.
module cal_divider #(
  parameter int NUM_W = 46,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

  logic [NUM_W-1:0] num_sh, quot_r;
  logic [DEN_W-1:0] rem_r, den_r;
  logic [CNT_W-1:0] cnt;
  logic             busy_r, done_r;

  logic [DEN_W:0] trial, trial_sub;
  logic           fits;

  always_comb begin
    trial     = {rem_r, num_sh[NUM_W-1]};
    fits      = trial >= {1'b0, den_r};
    trial_sub = trial - {1'b0, den_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_sh <= '0;
      quot_r <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      cnt    <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start) begin
        num_sh <= num;
        den_r  <= den;
        rem_r  <= '0;
        quot_r <= '0;
        cnt    <= '0;
        busy_r <= 1'b1;
      end else if (busy_r) begin
        rem_r  <= fits ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
        quot_r <= {quot_r[NUM_W-2:0], fits};
        num_sh <= num_sh << 1;
        cnt    <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_r;
  assign done = done_r;
  assign quot = quot_r;
endmodule

// File: rtl/cal_corrector.sv
`timescale 1ns/1ps
// Subtract offset, scale by gain, saturate, register.
module cal_corrector #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] raw,
  input  logic signed [DATA_W-1:0] offset,
  input  logic        [COEF_W-1:0] gain,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int PW = DATA_W + COEF_W + 2;
  localparam logic signed [PW-1:0] POS_LIM =
    $signed({{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
  localparam logic signed [PW-1:0] NEG_LIM =
    $signed({{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}});

  function automatic logic signed [DATA_W-1:0] correct_sample(
    input logic signed [DATA_W-1:0] r,
    input logic signed [DATA_W-1:0] o,
    input logic        [COEF_W-1:0] g
  );
    logic signed [PW-1:0] d_ext, g_ext, prod, scaled;
    d_ext  = PW'(r) - PW'(o);
    g_ext  = $signed({{(PW-COEF_W){1'b0}}, g});
    prod   = d_ext * g_ext;
    scaled = prod >>> (COEF_W - 1);
    if (scaled > POS_LIM)      return POS_LIM[DATA_W-1:0];
    else if (scaled < NEG_LIM) return NEG_LIM[DATA_W-1:0];
    else                       return scaled[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= correct_sample(raw, offset, gain);
    end
  end
endmodule

// File: rtl/cal_engine.sv
`timescale 1ns/1ps
module cal_engine
  import cal_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_wr,
  input  logic [2:0]               mode_wdata,
  input  logic                     raw_valid,
  input  logic signed [DATA_W-1:0] raw_data,
  output logic [2:0]               mode_q,
  output logic                     src_system,
  output logic                     cal_done,
  output logic                     dout_valid,
  output logic signed [DATA_W-1:0] dout,
  output logic signed [DATA_W-1:0] offset_q,
  output logic        [COEF_W-1:0] gain_q
);
  localparam int NUM_W = DATA_W + COEF_W - 2;
  localparam logic [COEF_W-1:0] GAIN_UNITY = {1'b1, {(COEF_W-1){1'b0}}};
  localparam logic [COEF_W-1:0] GAIN_MAX   = '1;
  localparam logic [NUM_W-1:0]  FS_NUM     = {{(DATA_W-1){1'b1}}, {(COEF_W-1){1'b0}}};

  cal_mode_e                mode_r;
  logic signed [DATA_W-1:0] offset_r;
  logic        [COEF_W-1:0] gain_r;
  logic                     done_r;

  logic             div_busy, div_done;
  logic [NUM_W-1:0] div_quot;

  // Named events shared with the checker.
  logic                   wr_accept, conv_fire, cap_fire;
  logic                   zero_fire, full_fire, full_degen, div_start;
  logic signed [DATA_W:0] cap_diff;

  function automatic logic [COEF_W-1:0] clamp_gain(input logic [NUM_W-1:0] q);
    return (q[NUM_W-1:COEF_W] != '0) ? GAIN_MAX : q[COEF_W-1:0];
  endfunction

  always_comb begin
    cap_diff   = $signed({raw_data[DATA_W-1], raw_data})
               - $signed({offset_r[DATA_W-1], offset_r});
    wr_accept  = mode_wr && (mode_r == MODE_IDLE);
    conv_fire  = raw_valid && (mode_r == MODE_IDLE);
    cap_fire   = raw_valid && (mode_r != MODE_IDLE) && !div_busy && !div_done;
    zero_fire  = cap_fire && is_zero_cap(mode_r);
    full_fire  = cap_fire && is_full_cap(mode_r);
    full_degen = full_fire && (cap_diff[DATA_W] || (cap_diff == '0));
    div_start  = full_fire && !full_degen;
  end

  cal_divider #(.NUM_W(NUM_W), .DEN_W(DATA_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (FS_NUM),
    .den   (cap_diff[DATA_W-1:0]),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  cal_corrector #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_corr (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (conv_fire),
    .raw       (raw_data),
    .offset    (offset_r),
    .gain      (gain_r),
    .out_valid (dout_valid),
    .out_data  (dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r   <= MODE_IDLE;
      offset_r <= '0;
      gain_r   <= GAIN_UNITY;
      done_r   <= 1'b0;
    end else begin
      if (wr_accept) begin
        mode_r <= norm_mode(mode_wdata);
        done_r <= 1'b0;
      end
      if (zero_fire) begin
        offset_r <= raw_data;
        mode_r   <= MODE_IDLE;
        done_r   <= 1'b1;
      end
      if (full_degen) begin
        gain_r <= GAIN_MAX;
        mode_r <= MODE_IDLE;
        done_r <= 1'b1;
      end
      if (div_done) begin
        gain_r <= clamp_gain(div_quot);
        mode_r <= MODE_IDLE;
        done_r <= 1'b1;
      end
    end
  end

  assign mode_q     = mode_r;
  assign src_system = is_system(mode_r);
  assign cal_done   = done_r;
  assign offset_q   = offset_r;
  assign gain_q     = gain_r;
endmodule

// File: rtl/cal_engine_chk.sv
`timescale 1ns/1ps
module cal_engine_chk #(
  parameter int DATA_W = 24,
  parameter int COEF_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_wr,
  input logic                     raw_valid,
  input logic [2:0]               mode_q,
  input logic                     cal_done,
  input logic                     dout_valid,
  input logic signed [DATA_W-1:0] offset_q,
  input logic        [COEF_W-1:0] gain_q
);
  p_conv_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> ($past(raw_valid) && ($past(mode_q) == 3'b000)));

  p_offset_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_q) |-> ($past(raw_valid) && $past(mode_q[2]) && !$past(mode_q[0])));

  p_done_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> (mode_q == 3'b000));

  p_gain_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_q) |-> ($past(mode_q[2]) && $past(mode_q[0])));

  p_busy_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && (mode_q != 3'b000)) |=> ((mode_q == $past(mode_q)) || (mode_q == 3'b000)));

  p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && (mode_q == 3'b000)) |=> !cal_done);
endmodule

bind cal_engine cal_engine_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_wr    (mode_wr),
  .raw_valid  (raw_valid),
  .mode_q     (mode_q),
  .cal_done   (cal_done),
  .dout_valid (dout_valid),
  .offset_q   (offset_q),
  .gain_q     (gain_q)
);

// File: tb/cal_engine_tb.sv
`timescale 1ns/1ps
module cal_engine_tb;
  localparam int DW = 24;
  localparam int CW = 24;
  localparam longint MAXC = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINC = -(64'sd1 <<< (DW-1));
  localparam longint GMAX = (64'sd1 <<< CW) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 mode_wr = 1'b0;
  logic [2:0]           mode_wdata = 3'b000;
  logic                 raw_valid = 1'b0;
  logic signed [DW-1:0] raw_data = '0;
  logic [2:0]           mode_q;
  logic                 src_system, cal_done, dout_valid;
  logic signed [DW-1:0] dout, offset_q;
  logic [CW-1:0]        gain_q;

  int     n_chk = 0;
  int     n_fail = 0;
  longint m_off = 0;
  longint m_gain = 64'sd1 <<< (CW-1);

  always #4 clk = ~clk;

  cal_engine #(.DATA_W(DW), .COEF_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .raw_valid(raw_valid), .raw_data(raw_data), .mode_q(mode_q),
    .src_system(src_system), .cal_done(cal_done), .dout_valid(dout_valid),
    .dout(dout), .offset_q(offset_q), .gain_q(gain_q)
  );

  function automatic longint exp_corr(input longint raw);
    longint s;
    s = ((raw - m_off) * m_gain) >>> (CW-1);
    if (s > MAXC) return MAXC;
    if (s < MINC) return MINC;
    return s;
  endfunction

  function automatic longint exp_gain(input longint d);
    longint q;
    if (d <= 0) return GMAX;
    q = (MAXC <<< (CW-1)) / d;
    return (q > GMAX) ? GMAX : q;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [2:0] code,
                       input logic vld, input longint raw);
    @(negedge clk);
    mode_wr    = wr;
    mode_wdata = code;
    raw_valid  = vld;
    raw_data   = DW'(raw);
    @(negedge clk);
    mode_wr   = 1'b0;
    raw_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !cal_done; i++) @(negedge clk);
  endtask

  task automatic conv(input string tag, input longint raw);
    drive(1'b0, 3'b000, 1'b1, raw);
    chk({tag, " valid"}, longint'(dout_valid), 1);
    chk({tag, " data"}, longint'(dout), exp_corr(raw));
  endtask

  task automatic zero_cal(input logic [2:0] code, input longint raw);
    drive(1'b1, code, 1'b0, 0);
    drive(1'b0, 3'b000, 1'b1, raw);
    m_off = raw;
  endtask

  task automatic full_cal(input logic [2:0] code, input longint raw);
    drive(1'b1, code, 1'b0, 0);
    drive(1'b0, 3'b000, 1'b1, raw);
    wait_done();
    m_gain = exp_gain(raw - m_off);
  endtask

  task automatic t_reset();
    chk("R1 mode", longint'(mode_q), 0);
    chk("R1 done", longint'(cal_done), 0);
    chk("R1 dout_valid", longint'(dout_valid), 0);
    chk("R1 offset", longint'(offset_q), 0);
    chk("R1 gain", longint'(gain_q), 64'sd1 <<< (CW-1));
    chk("R1 src", longint'(src_system), 0);
  endtask

  task automatic t_plain();
    conv("R2 unity pos", 1000);
    conv("R2 unity neg", -5);
    @(negedge clk);
    chk("R2 one-cycle pulse", longint'(dout_valid), 0);
  endtask

  task automatic t_zero();
    drive(1'b1, 3'b100, 1'b0, 0);
    chk("R4 int zero code", longint'(mode_q), 4);
    chk("R7 internal src", longint'(src_system), 0);
    drive(1'b0, 3'b000, 1'b1, 250);
    m_off = 250;
    chk("R5 no output", longint'(dout_valid), 0);
    chk("R5 offset", longint'(offset_q), 250);
    chk("R5 mode idle", longint'(mode_q), 0);
    chk("R5 done", longint'(cal_done), 1);
    conv("R2 after offset", 1250);
  endtask

  task automatic t_full();
    drive(1'b1, 3'b111, 1'b0, 0);
    chk("R8 done cleared", longint'(cal_done), 0);
    chk("R7 system src", longint'(src_system), 1);
    drive(1'b0, 3'b000, 1'b1, 250 + 4194304);
    chk("R6 still busy", longint'(mode_q), 7);
    drive(1'b0, 3'b000, 1'b1, 77);
    chk("R6 ignored sample", longint'(dout_valid), 0);
    chk("R6 gain not yet", longint'(gain_q), 64'sd1 <<< (CW-1));
    wait_done();
    m_gain = exp_gain(4194304);
    chk("R6 gain", longint'(gain_q), m_gain);
    chk("R6 mode idle", longint'(mode_q), 0);
    chk("R7 src off", longint'(src_system), 0);
    chk("R6 offset kept", longint'(offset_q), 250);
    conv("R2 scaled", 1250);
  endtask

  task automatic t_sat();
    drive(1'b0, 3'b000, 1'b1, 250 + 5000000);
    chk("R3 max clamp", longint'(dout), MAXC);
    drive(1'b0, 3'b000, 1'b1, MINC);
    chk("R3 min clamp", longint'(dout), MINC);
  endtask

  task automatic t_edges();
    zero_cal(3'b110, 0);
    chk("R5 sys zero offset", longint'(offset_q), 0);
    full_cal(3'b101, MAXC);
    chk("R6 exact unity", longint'(gain_q), 64'sd1 <<< (CW-1));
    full_cal(3'b111, 3);
    chk("R6 clamp small d", longint'(gain_q), GMAX);
    full_cal(3'b101, 4194304);
    chk("R6 gain 2x", longint'(gain_q), exp_gain(4194304));
    drive(1'b1, 3'b101, 1'b0, 0);
    drive(1'b0, 3'b000, 1'b1, -1);
    m_gain = GMAX;
    chk("R6 nonpositive d", longint'(gain_q), GMAX);
    chk("R6 degenerate done", longint'(cal_done), 1);
  endtask

  task automatic t_mode_rules();
    drive(1'b1, 3'b010, 1'b0, 0);
    chk("R4 reserved code", longint'(mode_q), 0);
    chk("R8 cleared by write", longint'(cal_done), 0);
    drive(1'b1, 3'b100, 1'b0, 0);
    drive(1'b1, 3'b111, 1'b0, 0);
    chk("R4 write while pending", longint'(mode_q), 4);
    drive(1'b0, 3'b000, 1'b1, 0);
    m_off = 0;
    chk("R4 capture completes", longint'(mode_q), 0);
  endtask

  task automatic t_collide();
    longint e;
    e = exp_corr(600);
    drive(1'b1, 3'b110, 1'b1, 600);
    chk("R9 converted", longint'(dout_valid), 1);
    chk("R9 old coefs", longint'(dout), e);
    chk("R9 mode taken", longint'(mode_q), 6);
    chk("R9 offset held", longint'(offset_q), 0);
    drive(1'b0, 3'b000, 1'b1, 40);
    m_off = 40;
    chk("R9 later capture", longint'(offset_q), 40);
    chk("R9 no output", longint'(dout_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_zero();
    t_full();
    t_sat();
    t_edges();
    t_mode_rules();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule